// File: doc/BRIEF.md
# Serial Flash Status and Protection Register Unit

This block holds the status and protection state of a serial NOR flash slave and answers the host over a mode-0 serial link. It keeps two volatile flags, write-enable and write-in-progress, and four protection bits: three region-select bits and one status-write lock bit that works together with an active-low write-protect pin. A read-status command returns the status byte on the serial output, and the byte repeats for as long as chip select stays low. Every repeat shows the flags as they are at that moment, so a host can poll the busy flag without sending a new command.

The block also decides whether the write-enable, status-write, page-program, sector-erase and bulk-erase commands are accepted. An accepted program or erase command produces a one-cycle start pulse with its address for the array controller. Each accepted modifying command holds the busy flag for a fixed, parameterized number of clock cycles. This stands in for the real cell timing. The serial pins are oversampled in the system clock domain. A command is judged when chip select returns high.

Top module: `flash_status_unit`

## Requirements
- R1: The status byte has the lock bit at bit 7, zeros at bits 6 and 5, the region bits at bits 4..2, write-enable at bit 1 and write-in-progress at bit 0. After reset all of these are 0.
- R2: After the read command 0x05, the status byte is driven most significant bit first. The first bit is driven from the eighth falling clock edge onward. so_en is high only while such a read is under way and is low otherwise.
- R3: While chip select stays low after the read command, the status byte repeats. Each repeat is taken fresh, so it shows the current flags, and a read works while a busy cycle runs.
- R4: An accepted status-write, program or erase sets write-in-progress for BUSY_CYCLES clocks. When that time ends, both write-in-progress and write-enable return to 0.
- R5: The single-byte command 0x06 sets write-enable.
- R6: While write-enable is 0, status-write, program, sector-erase and bulk-erase are ignored.
- R7: Page program is 0x02 followed by three address bytes, most significant byte first, and at least one data byte. Sector erase is 0xD8 followed by three address bytes. Both are rejected when the region bits hold a nonzero value n and the top 7-n address bits are all ones. For n=7 the whole array is protected. A rejected command leaves write-enable unchanged.
- R8: Bulk erase, the single-byte command 0xC7, executes only when all three region bits are 0.
- R9: When the lock bit is 1 and wp_n is low, status-write is rejected, and the lock and region bits cannot change.
- R10: Status-write is 0x01 followed by one byte. Only bits 7 and 4..2 of that byte are stored.
- R11: A command executes only if chip select rises on a byte boundary after exactly the byte count given for it. A truncated frame or a frame that stops mid-byte is ignored.
- R12: While write-in-progress is 1, all modifying commands, including 0x06, are ignored.
- R13: An accepted program or erase raises exactly one of prog_start, erase_start or bulk_start for one cycle. For program and sector erase, op_addr carries the received address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data into the block |
| wp_n | input | 1 | Active-low write-protect pin |
| so_data | output | 1 | Serial data out, valid while so_en is high |
| so_en | output | 1 | Output enable; the pin is high-impedance when low |
| prog_start | output | 1 | One-cycle pulse for an accepted page program |
| erase_start | output | 1 | One-cycle pulse for an accepted sector erase |
| bulk_start | output | 1 | One-cycle pulse for an accepted bulk erase |
| op_addr | output | 8*ADDR_BYTES | Address of the last accepted program or sector erase |

## Verification
The checks assume that cs_n, sck and mosi change well away from clk edges. They also assume that each sck level lasts several system clocks, so that every edge is seen exactly once after the one-stage sampling. The lock-stability check also assumes that wp_n does not toggle within a cycle of a frame's end. The bench drives all inputs on the falling clock edge and holds each serial clock phase for four system clocks. It changes wp_n only between frames, so these conditions hold throughout the stimulus.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    // Command codes
    typedef enum logic [7:0] {
        OP_WRSR = 8'h01,
        OP_PP   = 8'h02,
        OP_RDSR = 8'h05,
        OP_WREN = 8'h06,
        OP_BE   = 8'hC7,
        OP_SE   = 8'hD8
    } op_e;

    // Held status state
    typedef struct packed {
        logic       lock;   // status-write lock, works with wp_n
        logic [2:0] zone;   // protected region select
        logic       wel;    // write enable latch
        logic       wip;    // busy flag
    } sr_t;

    localparam int SPAN_BITS = 7;

    function automatic logic [7:0] sr_byte(sr_t s);
        return {s.lock, 2'b00, s.zone, s.wel, s.wip};
    endfunction

    // Region n (nonzero) covers the top 1/2^(7-n) of the array
    function automatic logic region_locked(logic [2:0] zone, logic [SPAN_BITS-1:0] top);
        logic hit;
        int   span;
        hit  = (zone != 3'd0);
        span = SPAN_BITS - int'(zone);
        for (int i = 0; i < SPAN_BITS; i++) begin
            if (i < span && !top[SPAN_BITS-1-i]) hit = 1'b0;
        end
        return hit;
    endfunction

endpackage

// File: rtl/fsr_shift_in.sv
module fsr_shift_in #(
    parameter  int ADDR_BYTES = 3,
    localparam int ADDR_W     = 8 * ADDR_BYTES,
    localparam int CNT_W      = $clog2(ADDR_BYTES + 3)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              bit_rise,
    input  logic              mosi_s,
    output logic [7:0]        opcode,
    output logic [7:0]        data1,
    output logic [ADDR_W-1:0] addr,
    output logic [2:0]        bit_idx,
    output logic [CNT_W-1:0]  byte_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(ADDR_BYTES + 2);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ALST = CNT_W'(ADDR_BYTES);

    logic [6:0]        sh;
    logic [7:0]        nxt;
    logic [ADDR_W+7:0] acat;

    assign nxt  = {sh, mosi_s};
    assign acat = {addr, nxt};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            opcode   <= '0;
            data1    <= '0;
            addr     <= '0;
            bit_idx  <= '0;
            byte_cnt <= '0;
        end else if (frame_start) begin
            bit_idx  <= '0;
            byte_cnt <= '0;
        end else if (bit_rise) begin
            sh      <= nxt[6:0];
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx == 3'd7) begin
                if (byte_cnt == '0)      opcode <= nxt;
                if (byte_cnt == CNT_ONE) data1  <= nxt;
                if (byte_cnt >= CNT_ONE && byte_cnt <= CNT_ALST)
                    addr <= acat[ADDR_W-1:0];
                if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + CNT_ONE;
            end
        end
    end

endmodule

// File: rtl/fsr_shift_out.sv
module fsr_shift_out (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_idle,
    input  logic       sck_fall,
    input  logic       rd_go,
    input  logic [7:0] stat,
    output logic       so_data,
    output logic       so_en
);
    logic [6:0] sh;
    logic [2:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            idx     <= '0;
            so_data <= 1'b0;
            so_en   <= 1'b0;
        end else if (cs_idle) begin
            so_en <= 1'b0;
            idx   <= '0;
        end else if (sck_fall && rd_go) begin
            so_en <= 1'b1;
            idx   <= idx + 3'd1;
            if (idx == 3'd0) begin
                // fresh copy at every byte start
                so_data <= stat[7];
                sh      <= stat[6:0];
            end else begin
                so_data <= sh[6];
                sh      <= {sh[5:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/fsr_regs.sv
module fsr_regs
    import fsr_pkg::*;
#(
    parameter  int ADDR_BYTES  = 3,
    parameter  int BUSY_CYCLES = 300,
    localparam int ADDR_W      = 8 * ADDR_BYTES,
    localparam int CNT_W       = $clog2(ADDR_BYTES + 3),
    localparam int TMR_W       = $clog2(BUSY_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_n,
    input  logic              frame_end,
    input  logic [7:0]        opcode,
    input  logic [7:0]        data1,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        bit_idx,
    input  logic [CNT_W-1:0]  byte_cnt,
    output sr_t               st,
    output logic              prog_start,
    output logic              erase_start,
    output logic              bulk_start,
    output logic [ADDR_W-1:0] op_addr
);
    localparam logic [CNT_W-1:0] LEN_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] LEN_WR  = CNT_W'(2);
    localparam logic [CNT_W-1:0] LEN_SE  = CNT_W'(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LEN_PP  = CNT_W'(ADDR_BYTES + 2);

    logic             aligned, ready, hw_lock, in_zone;
    logic             set_wel, do_wrsr, do_pp, do_se, do_be, go_busy;
    logic [TMR_W-1:0] timer;

    always_comb begin
        aligned = (bit_idx == 3'd0) && frame_end && !st.wip;
        ready   = aligned && st.wel;
        hw_lock = st.lock && !wp_n;
        in_zone = region_locked(st.zone, addr[ADDR_W-1 -: SPAN_BITS]);
        set_wel = aligned && (opcode == OP_WREN) && (byte_cnt == LEN_ONE);
        do_wrsr = ready && (opcode == OP_WRSR) && (byte_cnt == LEN_WR) && !hw_lock;
        do_pp   = ready && (opcode == OP_PP) && (byte_cnt == LEN_PP) && !in_zone;
        do_se   = ready && (opcode == OP_SE) && (byte_cnt == LEN_SE) && !in_zone;
        do_be   = ready && (opcode == OP_BE) && (byte_cnt == LEN_ONE) && (st.zone == 3'd0);
        go_busy = do_wrsr || do_pp || do_se || do_be;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= '0;
            timer       <= '0;
            prog_start  <= 1'b0;
            erase_start <= 1'b0;
            bulk_start  <= 1'b0;
            op_addr     <= '0;
        end else begin
            prog_start  <= do_pp;
            erase_start <= do_se;
            bulk_start  <= do_be;
            if (do_pp || do_se) op_addr <= addr;
            if (set_wel) st.wel <= 1'b1;
            if (do_wrsr) begin
                st.lock <= data1[7];
                st.zone <= data1[4:2];
            end
            if (go_busy) begin
                st.wip <= 1'b1;
                timer  <= TMR_W'(BUSY_CYCLES - 1);
            end else if (st.wip) begin
                if (timer == '0) begin
                    st.wip <= 1'b0;
                    st.wel <= 1'b0;
                end else begin
                    timer <= timer - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/flash_status_unit.sv
module flash_status_unit
    import fsr_pkg::*;
#(
    parameter int ADDR_BYTES  = 3,
    parameter int BUSY_CYCLES = 300
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cs_n,
    input  logic                    sck,
    input  logic                    mosi,
    input  logic                    wp_n,
    output logic                    so_data,
    output logic                    so_en,
    output logic                    prog_start,
    output logic                    erase_start,
    output logic                    bulk_start,
    output logic [8*ADDR_BYTES-1:0] op_addr
);
    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int CNT_W  = $clog2(ADDR_BYTES + 3);

    logic s_cs, p_cs, s_sck, p_sck, s_mosi;
    logic frame_start, frame_end, bit_rise, sck_fall, rd_go;

    logic [7:0]        opcode, data1;
    logic [ADDR_W-1:0] addr;
    logic [2:0]        bit_idx;
    logic [CNT_W-1:0]  byte_cnt;
    sr_t               st;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_cs   <= 1'b1;
            p_cs   <= 1'b1;
            s_sck  <= 1'b0;
            p_sck  <= 1'b0;
            s_mosi <= 1'b0;
        end else begin
            s_cs   <= cs_n;
            p_cs   <= s_cs;
            s_sck  <= sck;
            p_sck  <= s_sck;
            s_mosi <= mosi;
        end
    end

    assign frame_start = !s_cs && p_cs;
    assign frame_end   = s_cs && !p_cs;
    assign bit_rise    = !s_cs && s_sck && !p_sck;
    assign sck_fall    = !s_cs && !s_sck && p_sck;
    assign rd_go       = (opcode == OP_RDSR) && (byte_cnt != '0);

    fsr_shift_in #(.ADDR_BYTES(ADDR_BYTES)) u_in (
        .clk        (clk),
        .rst        (rst),
        .frame_start(frame_start),
        .bit_rise   (bit_rise),
        .mosi_s     (s_mosi),
        .opcode     (opcode),
        .data1      (data1),
        .addr       (addr),
        .bit_idx    (bit_idx),
        .byte_cnt   (byte_cnt)
    );

    fsr_regs #(.ADDR_BYTES(ADDR_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wp_n       (wp_n),
        .frame_end  (frame_end),
        .opcode     (opcode),
        .data1      (data1),
        .addr       (addr),
        .bit_idx    (bit_idx),
        .byte_cnt   (byte_cnt),
        .st         (st),
        .prog_start (prog_start),
        .erase_start(erase_start),
        .bulk_start (bulk_start),
        .op_addr    (op_addr)
    );

    fsr_shift_out u_out (
        .clk     (clk),
        .rst     (rst),
        .cs_idle (s_cs),
        .sck_fall(sck_fall),
        .rd_go   (rd_go),
        .stat    (sr_byte(st)),
        .so_data (so_data),
        .so_en   (so_en)
    );

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
    import fsr_pkg::*;
#(
    parameter  int ADDR_BYTES = 3,
    localparam int ADDR_W     = 8 * ADDR_BYTES
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              wp_n,
    input logic              so_en,
    input logic              prog_start,
    input logic              erase_start,
    input logic              bulk_start,
    input logic [ADDR_W-1:0] op_addr,
    input sr_t               st
);
    assert_one_start_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0({prog_start, erase_start, bulk_start}));

    assert_start_needs_wel_R6: assert property (@(posedge clk) disable iff (rst)
        (prog_start || erase_start || bulk_start) |-> st.wel);

    assert_start_busy_R4: assert property (@(posedge clk) disable iff (rst)
        (prog_start || erase_start || bulk_start) |-> st.wip);

    assert_wip_end_clears_wel_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(st.wip) |-> !st.wel);

    assert_bulk_unprotected_R8: assert property (@(posedge clk) disable iff (rst)
        bulk_start |-> (st.zone == 3'd0));

    assert_region_respected_R7: assert property (@(posedge clk) disable iff (rst)
        (prog_start || erase_start) |-> !region_locked(st.zone, op_addr[ADDR_W-1 -: SPAN_BITS]));

    assert_hw_lock_R9: assert property (@(posedge clk) disable iff (rst)
        (st.lock && !wp_n) |=> $stable({st.lock, st.zone}));

    assert_idle_hiz_R2: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !so_en);

endmodule

bind flash_status_unit fsr_checker #(.ADDR_BYTES(ADDR_BYTES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .wp_n       (wp_n),
    .so_en      (so_en),
    .prog_start (prog_start),
    .erase_start(erase_start),
    .bulk_start (bulk_start),
    .op_addr    (op_addr),
    .st         (st)
);

// File: tb/tb_flash_status_unit.sv
module tb_flash_status_unit;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int BUSY       = 300;

    logic        clk = 1'b0;
    logic        rst, cs_n, sck, mosi, wp_n;
    logic        so_data, so_en, prog_start, erase_start, bulk_start;
    logic [23:0] op_addr;

    int n_tests = 0, n_fail = 0;
    int n_pp = 0, n_se = 0, n_be = 0, oe_bad = 0;
    logic [23:0] pp_addr, se_addr;
    logic        rd_window = 1'b0;

    logic [7:0] exp_v[$];
    bit         exp_c[$];
    string      exp_t[$];
    logic [7:0] act_v[$];
    logic       act_e[$];

    flash_status_unit #(.ADDR_BYTES(3), .BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi), .wp_n(wp_n),
        .so_data(so_data), .so_en(so_en), .prog_start(prog_start),
        .erase_start(erase_start), .bulk_start(bulk_start), .op_addr(op_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Pulse and output-enable monitor
    always @(negedge clk) begin
        if (prog_start)  begin n_pp++; pp_addr = op_addr; end
        if (erase_start) begin n_se++; se_addr = op_addr; end
        if (bulk_start)  n_be++;
        if (so_en && !rd_window) oe_bad++;
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        while (act_v.size() > 0) begin
            logic [7:0] a;
            logic       e;
            a = act_v.pop_front();
            e = act_e.pop_front();
            if (exp_v.size() == 0) begin
                check(1'b0, "R3 unexpected byte", {24'h0, a}, 32'h0);
            end else begin
                logic [7:0] v;
                bit         c;
                string      t;
                v = exp_v.pop_front();
                c = exp_c.pop_front();
                t = exp_t.pop_front();
                if (c) begin
                    check(e === 1'b1, {t, " so_en"}, {31'h0, e}, 32'h1);
                    check(a === v, t, {24'h0, a}, {24'h0, v});
                end
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_b(input logic [7:0] v, input string t);
        exp_v.push_back(v); exp_c.push_back(1'b1); exp_t.push_back(t);
    endtask

    task automatic expect_x();
        exp_v.push_back(8'h00); exp_c.push_back(1'b0); exp_t.push_back("dc");
    endtask

    task automatic spi_bits(input logic [7:0] b, input int nb, output logic [7:0] r, output logic en);
        r  = '0;
        en = 1'b1;
        for (int i = 7; i > 7 - nb; i--) begin
            mosi = b[i];
            wait_clk(HALF);
            r[i] = so_data;
            en   = en & so_en;
            sck  = 1'b1;
            wait_clk(HALF);
            sck  = 1'b0;
        end
    endtask

    task automatic spi_byte(input logic [7:0] b, output logic [7:0] r, output logic en);
        spi_bits(b, 8, r, en);
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_end();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    // Sends n bytes taken from the top of v
    task automatic xfer(input int n, input logic [39:0] v);
        logic [7:0] r;
        logic       e;
        cs_begin();
        for (int k = 0; k < n; k++) spi_byte(v[39-8*k -: 8], r, e);
        cs_end();
    endtask

    task automatic read_status(input int n);
        logic [7:0] r;
        logic       e;
        rd_window = 1'b1;
        cs_begin();
        spi_byte(8'h05, r, e);
        for (int k = 0; k < n; k++) begin
            spi_byte(8'h00, r, e);
            act_v.push_back(r);
            act_e.push_back(e);
        end
        cs_end();
        rd_window = 1'b0;
        check(so_en === 1'b0, "R2 released after read", {31'h0, so_en}, 32'h0);
    endtask

    task automatic wait_busy();
        wait_clk(BUSY + 20);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic       e;
        rst = 1'b1; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; wp_n = 1'b1;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);

        // R1: reset state
        check(so_en === 1'b0, "R1 so_en after reset", {31'h0, so_en}, 32'h0);
        expect_b(8'h00, "R1 reset status");
        read_status(1);

        // R6: status write without write enable
        xfer(2, 40'h01_9C_000000);
        expect_b(8'h00, "R6 write ignored without enable");
        read_status(1);

        // R5: write enable
        xfer(1, 40'h06_00000000);
        expect_b(8'h02, "R5 enable set");
        read_status(1);

        // R10, R3, R4: status write, continuous read through busy
        xfer(2, 40'h01_6F_000000);
        expect_b(8'h0F, "R3 busy byte 0");
        expect_b(8'h0F, "R3 busy byte 1");
        expect_b(8'h0F, "R4 busy byte 2");
        expect_x();
        expect_x();
        expect_b(8'h0C, "R10 stored bits after busy");
        read_status(6);

        // R7: program into protected top sixteenth
        xfer(1, 40'h06_00000000);
        xfer(5, 40'h02_F00000_AA);
        check(n_pp == 0, "R7 protected program rejected", n_pp, 0);
        expect_b(8'h0E, "R7 enable kept after reject");
        read_status(1);

        // R13: program outside region
        xfer(5, 40'h02_100000_55);
        check(n_pp == 1, "R13 program pulse", n_pp, 1);
        check(pp_addr == 24'h100000, "R13 program address", pp_addr, 24'h100000);
        wait_busy();
        expect_b(8'h0C, "R4 enable cleared at end");
        read_status(1);

        // Sector erase: just below region accepted, inside rejected
        xfer(1, 40'h06_00000000);
        xfer(4, 40'h D8_EFFFFF_00);
        check(n_se == 1, "R13 erase pulse", n_se, 1);
        check(se_addr == 24'hEFFFFF, "R13 erase address", se_addr, 24'hEFFFFF);
        wait_busy();
        xfer(1, 40'h06_00000000);
        xfer(4, 40'hD8_F12345_00);
        check(n_se == 1, "R7 protected erase rejected", n_se, 1);
        xfer(1, 40'hC7_00000000);
        check(n_be == 0, "R8 bulk rejected with region set", n_be, 0);
        expect_b(8'h0E, "R7 state after rejects");
        read_status(1);

        // R11: framing
        xfer(1, 40'h01_00000000);
        cs_begin();
        spi_byte(8'h01, r, e);
        spi_bits(8'h00, 4, r, e);
        cs_end();
        xfer(3, 40'hD8_0000_0000);
        check(n_se == 1, "R11 short erase ignored", n_se, 1);
        expect_b(8'h0E, "R11 bad frames ignored");
        read_status(1);

        // R12: commands ignored while busy
        xfer(2, 40'h01_00_000000);
        xfer(1, 40'h06_00000000);
        xfer(1, 40'hC7_00000000);
        check(n_be == 0, "R12 bulk ignored while busy", n_be, 0);
        wait_busy();
        expect_b(8'h00, "R12 enable not set while busy");
        read_status(1);

        // R8: bulk erase with region clear
        xfer(1, 40'h06_00000000);
        xfer(1, 40'hC7_00000000);
        check(n_be == 1, "R8 bulk accepted", n_be, 1);
        wait_busy();

        // R7: whole array protected
        xfer(1, 40'h06_00000000);
        xfer(2, 40'h01_1C_000000);
        wait_busy();
        xfer(1, 40'h06_00000000);
        xfer(5, 40'h02_000000_11);
        check(n_pp == 1, "R7 full protect rejects low address", n_pp, 1);
        expect_b(8'h1E, "R7 full region status");
        read_status(1);

        // R9: hardware protection
        wp_n = 1'b0;
        wait_clk(2);
        xfer(2, 40'h01_9C_000000);
        wait_busy();
        expect_b(8'h9C, "R9 lock set while unlocked");
        read_status(1);
        xfer(1, 40'h06_00000000);
        xfer(2, 40'h01_00_000000);
        wait_clk(4);
        expect_b(8'h9E, "R9 write rejected when locked");
        read_status(1);
        wp_n = 1'b1;
        wait_clk(2);
        xfer(2, 40'h01_00_000000);
        wait_busy();
        expect_b(8'h00, "R9 write accepted with pin high");
        read_status(1);

        wait_clk(4);
        check(oe_bad == 0, "R2 no output outside reads", oe_bad, 0);
        check(exp_v.size() == 0, "R3 all expected bytes seen", exp_v.size(), 0);
        check(n_pp == 1 && n_se == 1 && n_be == 1, "R13 total pulses", n_pp + n_se + n_be, 3);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule